// File: doc/BRIEF.md
# Banked General Register File

This block is the general register storage of a small 4-bit processor core. It holds several banks of eight nibble-wide registers. Which bank the datapath sees is set by a small piece of bank state: an enable bit and a select field. The bank actually addressed is the select field masked by the enable bit. When the enable bit is clear, bank 0 is used whatever the select field holds. This lets interrupt handlers switch to a private bank, or stay in bank 0, by loading a single bit.

The datapath reads one register as a nibble, or an adjacent register pair as a byte, through two independent combinational read ports. It writes through one clocked port whose width flag picks a nibble or a pair. Control commands set and clear the enable bit and load the select field. Other commands export the whole bank state as one word and reload it as one word, so that a call or interrupt sequence can push and pop it. Interrupt entry loads the enable bit from a value taken from the vector entry. Instruction decode, the ALU and the stack memory sit outside this block.

Top module: `banked_regfile`

## Requirements
- R1: While reset is low and after its release, every register, the enable bit and the select field are 0. `state_out` reads 0 and `eff_bank_out` reads 0.
- R2: The effective bank equals the select field ANDed bitwise with the enable bit. With the enable bit at 0, reads and writes go to bank 0 for any select value.
- R3: `ctl_op` = 3 (select load) copies `bank_sel_in` into the select field at the clock edge and leaves the enable bit unchanged.
- R4: `ctl_op` = 1 sets the enable bit and `ctl_op` = 2 clears it. Both leave the select field unchanged.
- R5: `state_out` is {enable, select}, with the enable bit in bit 2 and the select field in bits 1:0. `ctl_op` = 4 (state load) writes both from `state_in` in the same layout.
- R6: `ctl_op` = 5 (interrupt entry) loads the enable bit from `irq_en_in` and leaves the select field unchanged.
- R7: A nibble write (`wr_en`=1, `wr_pair`=0) stores `wr_data[3:0]` into register `wr_idx` of the effective bank. Registers are numbered X=0, A=1, B=2, C=3, D=4, E=5, H=6, L=7. No other register in any bank changes.
- R8: Pair p (XA=0, BC=1, DE=2, HL=3) is registers 2p and 2p+1, with register 2p in the upper nibble. `rd_pair_data` returns that byte. A pair write (`wr_pair`=1) stores `wr_data` into both halves in one edge, taking p from `wr_idx[2:1]` and ignoring `wr_idx[0]`.
- R9: A write in the same cycle as a bank-state change goes to the bank that was effective before that edge.
- R10: `ctl_op` = 0, and the unused codes 6 and 7, leave the bank state unchanged.
- R11: With `wr_en`=0, no register changes, whatever `wr_idx`, `wr_pair` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_op | input | 3 | Bank-state command code |
| bank_sel_in | input | 2 | Bank number for a select load |
| state_in | input | 3 | Saved bank state for a state load |
| irq_en_in | input | 1 | Enable value from the interrupt vector |
| state_out | output | 3 | Current bank state {enable, select} |
| eff_bank_out | output | 2 | Effective bank |
| wr_en | input | 1 | Write strobe |
| wr_pair | input | 1 | 1 = byte pair write, 0 = nibble write |
| wr_idx | input | 3 | Register index (pair index in bits 2:1) |
| wr_data | input | 8 | Write data (nibble in bits 3:0) |
| rd_nib_idx | input | 3 | Nibble read register index |
| rd_nib_data | output | 4 | Nibble read data |
| rd_pair_idx | input | 2 | Pair read index |
| rd_pair_data | output | 8 | Pair read data |

## Verification
The bench builds the block with its default parameters: four banks of eight 4-bit registers. This keeps the whole storage of 32 nibbles small enough to sweep after every scenario. With these values the select field spans banks 0 to 3, so bank 3 is reachable and shows both select bits being masked by the enable bit. The vector walk changes bank state while writing, which places writes exactly on the edge where the effective bank moves. The later sweeps then show that each write landed in the old bank and left the other three untouched.

// File: rtl/brf_pkg.sv
package brf_pkg;

  typedef enum logic [2:0] {
    BRF_NOP      = 3'd0,
    BRF_EN_SET   = 3'd1,
    BRF_EN_CLR   = 3'd2,
    BRF_SEL_LOAD = 3'd3,
    BRF_STATE_LD = 3'd4,
    BRF_IRQ_ENT  = 3'd5
  } brf_op_e;

endpackage

// File: rtl/brf_bank_ctrl.sv
module brf_bank_ctrl
  import brf_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  brf_op_e           op_i,
  input  logic [BANK_W-1:0] sel_in_i,
  input  logic [BANK_W:0]   state_in_i,
  input  logic              irq_en_i,
  output logic              en_o,
  output logic [BANK_W-1:0] sel_o,
  output logic [BANK_W:0]   state_o
);

  logic              en_q, en_nxt;
  logic [BANK_W-1:0] sel_q, sel_nxt;

  // named events for the checks below
  logic en_cmd_ev;
  logic sel_cmd_ev;

  assign en_cmd_ev  = (op_i == BRF_EN_SET) || (op_i == BRF_EN_CLR) ||
                      (op_i == BRF_STATE_LD) || (op_i == BRF_IRQ_ENT);
  assign sel_cmd_ev = (op_i == BRF_SEL_LOAD) || (op_i == BRF_STATE_LD);

  always_comb begin
    en_nxt  = en_q;
    sel_nxt = sel_q;
    case (op_i)
      BRF_EN_SET:   en_nxt = 1'b1;
      BRF_EN_CLR:   en_nxt = 1'b0;
      BRF_SEL_LOAD: sel_nxt = sel_in_i;
      BRF_STATE_LD: begin
        en_nxt  = state_in_i[BANK_W];
        sel_nxt = state_in_i[BANK_W-1:0];
      end
      BRF_IRQ_ENT:  en_nxt = irq_en_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      en_q  <= en_nxt;
      sel_q <= sel_nxt;
    end
  end

  assign en_o    = en_q;
  assign sel_o   = sel_q;
  assign state_o = {en_q, sel_q};

  assert_en_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_cmd_ev |=> $stable(en_q));
  assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_cmd_ev |=> $stable(sel_q));
  assert_sel_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == BRF_SEL_LOAD) |=> (sel_q == $past(sel_in_i)) && $stable(en_q));
  assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == BRF_EN_SET) |=> en_q && $stable(sel_q));
  assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == BRF_EN_CLR) |=> !en_q && $stable(sel_q));
  assert_state_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == BRF_STATE_LD) |=> (state_o == $past(state_in_i)));
  assert_irq_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == BRF_IRQ_ENT) |=> (en_q == $past(irq_en_i)) && $stable(sel_q));

endmodule

// File: rtl/brf_addr_map.sv
module brf_addr_map #(
  parameter int REGS  = 8,
  parameter int BANKS = 4,
  localparam int REG_W  = $clog2(REGS),
  localparam int BANK_W = $clog2(BANKS),
  localparam int PAIR_W = REG_W - 1,
  localparam int PHYS_W = $clog2(REGS * BANKS)
) (
  input  logic              en_i,
  input  logic [BANK_W-1:0] sel_i,
  input  logic [REG_W-1:0]  rd_nib_idx_i,
  input  logic [PAIR_W-1:0] rd_pair_idx_i,
  input  logic [REG_W-1:0]  wr_idx_i,
  output logic [BANK_W-1:0] eff_bank_o,
  output logic [PHYS_W-1:0] rd_nib_phys_o,
  output logic [PHYS_W-1:0] rd_hi_phys_o,
  output logic [PHYS_W-1:0] rd_lo_phys_o,
  output logic [PHYS_W-1:0] wr_nib_phys_o,
  output logic [PHYS_W-1:0] wr_hi_phys_o,
  output logic [PHYS_W-1:0] wr_lo_phys_o
);

  function automatic logic [BANK_W-1:0] eff_bank_f(input logic en,
                                                   input logic [BANK_W-1:0] sel);
    return sel & {BANK_W{en}};
  endfunction

  function automatic logic [PHYS_W-1:0] phys_f(input logic [BANK_W-1:0] bank,
                                               input logic [REG_W-1:0] r);
    return PHYS_W'(bank) * PHYS_W'(REGS) + PHYS_W'(r);
  endfunction

  // upper half of a pair is the even-numbered register
  function automatic logic [REG_W-1:0] pair_reg_f(input logic [PAIR_W-1:0] p,
                                                  input logic lower);
    return {p, lower};
  endfunction

  logic [BANK_W-1:0] bank;
  logic [PAIR_W-1:0] wr_pair_idx;

  assign bank        = eff_bank_f(en_i, sel_i);
  assign wr_pair_idx = wr_idx_i[REG_W-1:1];
  assign eff_bank_o  = bank;

  assign rd_nib_phys_o = phys_f(bank, rd_nib_idx_i);
  assign rd_hi_phys_o  = phys_f(bank, pair_reg_f(rd_pair_idx_i, 1'b0));
  assign rd_lo_phys_o  = phys_f(bank, pair_reg_f(rd_pair_idx_i, 1'b1));
  assign wr_nib_phys_o = phys_f(bank, wr_idx_i);
  assign wr_hi_phys_o  = phys_f(bank, pair_reg_f(wr_pair_idx, 1'b0));
  assign wr_lo_phys_o  = phys_f(bank, pair_reg_f(wr_pair_idx, 1'b1));

endmodule

// File: rtl/brf_storage.sv
module brf_storage #(
  parameter int NIB_W = 4,
  parameter int DEPTH = 32,
  localparam int PHYS_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_fire_i,
  input  logic               wr_pair_i,
  input  logic [PHYS_W-1:0]  wr_nib_phys_i,
  input  logic [PHYS_W-1:0]  wr_hi_phys_i,
  input  logic [PHYS_W-1:0]  wr_lo_phys_i,
  input  logic [2*NIB_W-1:0] wr_data_i,
  input  logic [PHYS_W-1:0]  rd_nib_phys_i,
  input  logic [PHYS_W-1:0]  rd_hi_phys_i,
  input  logic [PHYS_W-1:0]  rd_lo_phys_i,
  output logic [NIB_W-1:0]   rd_nib_o,
  output logic [2*NIB_W-1:0] rd_pair_o
);

  logic [NIB_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] hit_upper;
  logic [DEPTH-1:0] hit_lower;

  // per-entry write selects
  for (genvar e = 0; e < DEPTH; e++) begin : g_hit
    assign hit_upper[e] = wr_fire_i && wr_pair_i && (wr_hi_phys_i == PHYS_W'(e));
    assign hit_lower[e] = wr_fire_i &&
                          (wr_pair_i ? (wr_lo_phys_i  == PHYS_W'(e))
                                     : (wr_nib_phys_i == PHYS_W'(e)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (hit_upper[e])      mem[e] <= wr_data_i[2*NIB_W-1:NIB_W];
        else if (hit_lower[e]) mem[e] <= wr_data_i[NIB_W-1:0];
      end
    end
  end

  assign rd_nib_o  = mem[rd_nib_phys_i];
  assign rd_pair_o = {mem[rd_hi_phys_i], mem[rd_lo_phys_i]};

  assert_one_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_upper));
  assert_pair_halves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire_i && wr_pair_i) |-> ($countones(hit_upper | hit_lower) == 2));
  assert_nib_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire_i && !wr_pair_i) |=>
      (mem[$past(wr_nib_phys_i)] == $past(wr_data_i[NIB_W-1:0])));
  assert_pair_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire_i && wr_pair_i) |=>
      ({mem[$past(wr_hi_phys_i)], mem[$past(wr_lo_phys_i)]} == $past(wr_data_i)));
  assert_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire_i |-> ((hit_upper | hit_lower) == '0));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int REGS  = 8,
  parameter int BANKS = 4,
  localparam int REG_W   = $clog2(REGS),
  localparam int BANK_W  = $clog2(BANKS),
  localparam int PAIR_W  = REG_W - 1,
  localparam int STATE_W = BANK_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         ctl_op,
  input  logic [BANK_W-1:0]  bank_sel_in,
  input  logic [STATE_W-1:0] state_in,
  input  logic               irq_en_in,
  output logic [STATE_W-1:0] state_out,
  output logic [BANK_W-1:0]  eff_bank_out,
  input  logic               wr_en,
  input  logic               wr_pair,
  input  logic [REG_W-1:0]   wr_idx,
  input  logic [2*NIB_W-1:0] wr_data,
  input  logic [REG_W-1:0]   rd_nib_idx,
  output logic [NIB_W-1:0]   rd_nib_data,
  input  logic [PAIR_W-1:0]  rd_pair_idx,
  output logic [2*NIB_W-1:0] rd_pair_data
);

  localparam int DEPTH  = REGS * BANKS;
  localparam int PHYS_W = $clog2(DEPTH);

  brf_op_e           op;
  logic              bank_en;
  logic [BANK_W-1:0] bank_sel;
  logic [BANK_W-1:0] eff_bank;
  logic              wr_fire_ev;
  logic [PHYS_W-1:0] rd_nib_phys, rd_hi_phys, rd_lo_phys;
  logic [PHYS_W-1:0] wr_nib_phys, wr_hi_phys, wr_lo_phys;

  assign op         = brf_op_e'(ctl_op);
  assign wr_fire_ev = wr_en;

  brf_bank_ctrl #(.BANK_W(BANK_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op),
    .sel_in_i   (bank_sel_in),
    .state_in_i (state_in),
    .irq_en_i   (irq_en_in),
    .en_o       (bank_en),
    .sel_o      (bank_sel),
    .state_o    (state_out)
  );

  brf_addr_map #(.REGS(REGS), .BANKS(BANKS)) u_map (
    .en_i          (bank_en),
    .sel_i         (bank_sel),
    .rd_nib_idx_i  (rd_nib_idx),
    .rd_pair_idx_i (rd_pair_idx),
    .wr_idx_i      (wr_idx),
    .eff_bank_o    (eff_bank),
    .rd_nib_phys_o (rd_nib_phys),
    .rd_hi_phys_o  (rd_hi_phys),
    .rd_lo_phys_o  (rd_lo_phys),
    .wr_nib_phys_o (wr_nib_phys),
    .wr_hi_phys_o  (wr_hi_phys),
    .wr_lo_phys_o  (wr_lo_phys)
  );

  brf_storage #(.NIB_W(NIB_W), .DEPTH(DEPTH)) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_fire_i     (wr_fire_ev),
    .wr_pair_i     (wr_pair),
    .wr_nib_phys_i (wr_nib_phys),
    .wr_hi_phys_i  (wr_hi_phys),
    .wr_lo_phys_i  (wr_lo_phys),
    .wr_data_i     (wr_data),
    .rd_nib_phys_i (rd_nib_phys),
    .rd_hi_phys_i  (rd_hi_phys),
    .rd_lo_phys_i  (rd_lo_phys),
    .rd_nib_o      (rd_nib_data),
    .rd_pair_o     (rd_pair_data)
  );

  assign eff_bank_out = eff_bank;

  assert_bank0_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !state_out[STATE_W-1] |-> (eff_bank_out == '0));
  assert_bank_is_sel_when_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_out[STATE_W-1] |-> (eff_bank_out == state_out[BANK_W-1:0]));
  assert_ports_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_nib_idx == {rd_pair_idx, 1'b0}) |-> (rd_pair_data[2*NIB_W-1:NIB_W] == rd_nib_data));

endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // {op3, sel2, state3, irq1, we1, wpair1, widx3, wdata8, rnib3, rpair2, exp_state3}
  localparam logic [29:0] VEC [NV] = '{
    {3'd3, 2'd3, 3'd0, 1'b0, 1'b1, 1'b0, 3'd1, 8'h05, 3'd1, 2'd0, 3'b011},
    {3'd1, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 3'd0, 8'h0A, 3'd0, 2'd0, 3'b111},
    {3'd0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b1, 3'd2, 8'h3C, 3'd3, 2'd1, 3'b111},
    {3'd3, 2'd1, 3'd0, 1'b0, 1'b1, 1'b1, 3'd6, 8'h96, 3'd0, 2'd3, 3'b101},
    {3'd0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 3'd7, 8'h0E, 3'd7, 2'd3, 3'b101},
    {3'd2, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 3'd2, 8'h07, 3'd0, 2'd0, 3'b001},
    {3'd4, 2'd0, 3'd6, 1'b0, 1'b0, 1'b0, 3'd0, 8'hFF, 3'd0, 2'd0, 3'b110},
    {3'd5, 2'd0, 3'd0, 1'b0, 1'b1, 1'b1, 3'd0, 8'h21, 3'd3, 2'd1, 3'b010},
    {3'd4, 2'd0, 3'd7, 1'b0, 1'b1, 1'b0, 3'd3, 8'h0B, 3'd6, 2'd3, 3'b111},
    {3'd7, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 3'd5, 8'h04, 3'd5, 2'd2, 3'b111},
    {3'd5, 2'd0, 3'd0, 1'b1, 1'b1, 1'b1, 3'd5, 8'h5A, 3'd4, 2'd2, 3'b111},
    {3'd3, 2'd2, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 3'd0, 2'd0, 3'b110}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ctl_op = '0;
  logic [1:0] bank_sel_in = '0;
  logic [2:0] state_in = '0;
  logic       irq_en_in = 1'b0;
  logic [2:0] state_out;
  logic [1:0] eff_bank_out;
  logic       wr_en = 1'b0;
  logic       wr_pair = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_nib_idx = '0;
  logic [3:0] rd_nib_data;
  logic [1:0] rd_pair_idx = '0;
  logic [7:0] rd_pair_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] mdl [4][8];
  logic [2:0] mdl_state;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .ctl_op(ctl_op), .bank_sel_in(bank_sel_in),
    .state_in(state_in), .irq_en_in(irq_en_in), .state_out(state_out),
    .eff_bank_out(eff_bank_out), .wr_en(wr_en), .wr_pair(wr_pair),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_nib_idx(rd_nib_idx),
    .rd_nib_data(rd_nib_data), .rd_pair_idx(rd_pair_idx),
    .rd_pair_data(rd_pair_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] bank_of(input logic [2:0] st);
    return st[2] ? st[1:0] : 2'd0;
  endfunction

  task automatic model_clear();
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 8; r++) mdl[b][r] = 4'h0;
    mdl_state = 3'b000;
  endtask

  // loads a bank state through the state-load command, then checks every register
  task automatic sweep_bank(input logic [2:0] st, input string tag);
    @(negedge clk);
    ctl_op = 3'd4; state_in = st; wr_en = 1'b0;
    @(posedge clk); #1;
    ctl_op = 3'd0;
    mdl_state = st;
    chk({tag, " R5 state"}, {5'd0, state_out}, {5'd0, st});
    chk({tag, " R2 bank"}, {6'd0, eff_bank_out}, {6'd0, bank_of(st)});
    for (int r = 0; r < 8; r++) begin
      rd_nib_idx = 3'(r); #1;
      chk({tag, " R7 R9 nibble"}, {4'd0, rd_nib_data}, {4'd0, mdl[bank_of(st)][r]});
    end
    for (int p = 0; p < 4; p++) begin
      rd_pair_idx = 2'(p); #1;
      chk({tag, " R8 pair"}, rd_pair_data,
          {mdl[bank_of(st)][2*p], mdl[bank_of(st)][2*p+1]});
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [1:0] old_bank;
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 state during reset", {5'd0, state_out}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 state after reset", {5'd0, state_out}, 8'h00);
    chk("R1 bank after reset", {6'd0, eff_bank_out}, 8'h00);
    chk("R1 nibble after reset", {4'd0, rd_nib_data}, 8'h00);
    chk("R1 pair after reset", rd_pair_data, 8'h00);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {ctl_op, bank_sel_in, state_in, irq_en_in, wr_en, wr_pair, wr_idx, wr_data,
       rd_nib_idx, rd_pair_idx} = VEC[v][29:3];
      @(posedge clk); #1;
      old_bank = bank_of(mdl_state);
      if (wr_en) begin
        if (wr_pair) begin
          mdl[old_bank][{wr_idx[2:1], 1'b0}] = wr_data[7:4];
          mdl[old_bank][{wr_idx[2:1], 1'b1}] = wr_data[3:0];
        end else begin
          mdl[old_bank][wr_idx] = wr_data[3:0];
        end
      end
      mdl_state = VEC[v][2:0];
      chk($sformatf("R3 R4 R5 R6 R10 state vec%0d", v), {5'd0, state_out}, {5'd0, mdl_state});
      chk($sformatf("R2 bank vec%0d", v), {6'd0, eff_bank_out}, {6'd0, bank_of(mdl_state)});
      chk($sformatf("R7 R11 nibble vec%0d", v), {4'd0, rd_nib_data},
          {4'd0, mdl[bank_of(mdl_state)][rd_nib_idx]});
      chk($sformatf("R8 pair vec%0d", v), rd_pair_data,
          {mdl[bank_of(mdl_state)][{rd_pair_idx, 1'b0}],
           mdl[bank_of(mdl_state)][{rd_pair_idx, 1'b1}]});
    end

    // full sweeps: writes landed in the old bank and nowhere else
    for (int b = 0; b < 4; b++) sweep_bank({1'b1, 2'(b)}, $sformatf("sweep bank%0d", b));
    // enable off masks any select value to bank 0
    sweep_bank(3'b011, "R2 masked sel3");
    sweep_bank(3'b010, "R2 masked sel2");

    // reset in mid-run clears every bank
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 state in reset", {5'd0, state_out}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    for (int b = 0; b < 4; b++) sweep_bank({1'b1, 2'(b)}, $sformatf("R1 cleared bank%0d", b));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule